// File: doc/BRIEF.md
# Branch Stall and Squash Control

This unit is the hazard controller for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). In this pipeline a branch's direction and target are only known once the branch reaches the memory stage. Each cycle the unit reads three flags that mark a branch in the decode, execute and memory stages, along with the taken outcome that the memory stage reports. It drives a three-way command onto each of the three pipeline latches in front of memory: transfer, stall (hold the contents) or bubble (load an invalid slot). It also drives a fetch-address hold and a redirect select that loads the branch target into the program counter.

A mode input selects one of two policies. The conservative policy stops fetching while a branch is still unresolved. The speculative policy keeps fetching down the fall-through path and, on a taken outcome, cancels everything younger than the branch. Cancelling is safe because no instruction writes architectural state before the memory or writeback stage. Two free-running counters total the fetch-hold cycles and the cancelled slots, so the cost of each policy can be read at the ports.

Top module: `branch_hazard_ctrl`

## Requirements
- R1: After reset both counters read zero.
- R2: Command codes are transfer 2'b00, stall 2'b01 and bubble 2'b10. With no branch flag set in any stage, all three latch commands are transfer, and fetch hold and redirect are both 0, in both modes.
- R3: In stall mode (mode=0), when a branch is in decode or execute and no taken branch is in memory, the fetch/decode latch gets stall, the decode/execute latch gets bubble, the execute/memory latch gets transfer and fetch hold is 1.
- R4: In either mode, a taken branch in memory (mem_br=1, mem_taken=1) sets redirect to 1 and fetch hold to 0, and drives bubble onto all three latches. This holds even when decode or execute also flags a branch: the older branch wins and the younger ones are cancelled.
- R5: A not-taken branch in memory, with no branch in decode or execute, leaves every command at transfer with redirect 0.
- R6: In fetch-and-cancel mode (mode=1), branches in decode or execute never cause a stall. Without a taken branch in memory, every command is transfer and fetch hold is 0.
- R7: The stall counter increases by exactly one after each cycle in which fetch hold is 1, and is otherwise unchanged.
- R8: On a cycle with a taken branch in memory, the squash counter increases by 1 in stall mode and by 3 in fetch-and-cancel mode. Otherwise it is unchanged.
- R9: mem_taken has no effect on any output while mem_br is 0.
- R10: When one branch passes through decode, execute and memory, the combined penalty (stall plus squash increments) is 3 for taken and 2 for not taken in stall mode. In fetch-and-cancel mode it is 3 for taken and 0 for not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = stall until resolved, 1 = fetch and cancel |
| id_br | input | 1 | Branch present in decode |
| ex_br | input | 1 | Branch present in execute |
| mem_br | input | 1 | Branch present in memory |
| mem_taken | input | 1 | Outcome of the memory-stage branch |
| if_id_cmd | output | 2 | Command for the fetch/decode latch |
| id_ex_cmd | output | 2 | Command for the decode/execute latch |
| ex_mem_cmd | output | 2 | Command for the execute/memory latch |
| pc_hold | output | 1 | Keep the fetch address unchanged |
| pc_redirect | output | 1 | Load the branch target into the fetch address |
| stall_cnt | output | CNT_W | Running total of fetch-hold cycles |
| squash_cnt | output | CNT_W | Running total of cancelled slots |

## Verification
The interesting collision is a taken resolution in memory arriving in the same cycle as a younger branch flag in decode or execute. In stall mode that younger flag would otherwise ask for a hold. The bench sweeps all 32 combinations of mode and the four stage inputs, which produces this case in both modes. It checks that redirect, with bubbles on every latch, wins over the hold, and that the counters credit only the squash. Scripted single-branch passages then confirm the per-branch penalty totals from the counter deltas.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
    typedef enum logic [1:0] {
        LATCH_XFER   = 2'b00,
        LATCH_STALL  = 2'b01,
        LATCH_BUBBLE = 2'b10
    } latch_cmd_e;

    typedef struct packed {
        latch_cmd_e if_id;
        latch_cmd_e id_ex;
        latch_cmd_e ex_mem;
        logic       hold;
        logic       redirect;
        logic       resolve_taken;
    } ctrl_t;
endpackage

// File: rtl/bhc_policy.sv
module bhc_policy
    import bhc_pkg::*;
(
    input  logic  mode,
    input  logic  id_br,
    input  logic  ex_br,
    input  logic  mem_br,
    input  logic  mem_taken,
    output ctrl_t ctrl
);
    logic taken_now;
    logic young_br;

    always_comb begin
        taken_now = mem_br & mem_taken;
        young_br  = id_br | ex_br;
        ctrl = '{if_id: LATCH_XFER, id_ex: LATCH_XFER, ex_mem: LATCH_XFER,
                 hold: 1'b0, redirect: 1'b0, resolve_taken: 1'b0};
        if (taken_now) begin
            ctrl.if_id         = LATCH_BUBBLE;
            ctrl.id_ex         = LATCH_BUBBLE;
            ctrl.ex_mem        = LATCH_BUBBLE;
            ctrl.redirect      = 1'b1;
            ctrl.resolve_taken = 1'b1;
        end else if (!mode && young_br) begin
            ctrl.if_id = LATCH_STALL;
            ctrl.id_ex = LATCH_BUBBLE;
            ctrl.hold  = 1'b1;
        end
    end
endmodule

// File: rtl/bhc_counters.sv
module bhc_counters #(
    parameter int CNT_W        = 16,
    parameter int CANCEL_SLOTS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic             hold,
    input  logic             resolve_taken,
    output logic [CNT_W-1:0] stall_cnt,
    output logic [CNT_W-1:0] squash_cnt
);
    localparam logic [CNT_W-1:0] SPEC_INC = CNT_W'(CANCEL_SLOTS);
    localparam logic [CNT_W-1:0] SAFE_INC = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] stalls;
        logic [CNT_W-1:0] squashes;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hold)
            cnt_d.stalls = cnt_q.stalls + SAFE_INC;
        if (resolve_taken)
            cnt_d.squashes = cnt_q.squashes + (mode ? SPEC_INC : SAFE_INC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign stall_cnt  = cnt_q.stalls;
    assign squash_cnt = cnt_q.squashes;
endmodule

// File: rtl/branch_hazard_ctrl.sv
module branch_hazard_ctrl
    import bhc_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int CANCEL_SLOTS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic             id_br,
    input  logic             ex_br,
    input  logic             mem_br,
    input  logic             mem_taken,
    output logic [1:0]       if_id_cmd,
    output logic [1:0]       id_ex_cmd,
    output logic [1:0]       ex_mem_cmd,
    output logic             pc_hold,
    output logic             pc_redirect,
    output logic [CNT_W-1:0] stall_cnt,
    output logic [CNT_W-1:0] squash_cnt
);
    ctrl_t ctrl;

    bhc_policy u_policy (
        .mode      (mode),
        .id_br     (id_br),
        .ex_br     (ex_br),
        .mem_br    (mem_br),
        .mem_taken (mem_taken),
        .ctrl      (ctrl)
    );

    bhc_counters #(.CNT_W(CNT_W), .CANCEL_SLOTS(CANCEL_SLOTS)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode),
        .hold          (ctrl.hold),
        .resolve_taken (ctrl.resolve_taken),
        .stall_cnt     (stall_cnt),
        .squash_cnt    (squash_cnt)
    );

    assign if_id_cmd   = ctrl.if_id;
    assign id_ex_cmd   = ctrl.id_ex;
    assign ex_mem_cmd  = ctrl.ex_mem;
    assign pc_hold     = ctrl.hold;
    assign pc_redirect = ctrl.redirect;
endmodule

// File: rtl/bhc_checker.sv
module bhc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode,
    input logic             id_br,
    input logic             ex_br,
    input logic             mem_br,
    input logic             mem_taken,
    input logic [1:0]       if_id_cmd,
    input logic [1:0]       id_ex_cmd,
    input logic [1:0]       ex_mem_cmd,
    input logic             pc_hold,
    input logic             pc_redirect,
    input logic [CNT_W-1:0] stall_cnt,
    input logic [CNT_W-1:0] squash_cnt
);
    assert_taken_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_br && mem_taken) |-> (pc_redirect && !pc_hold && if_id_cmd == 2'b10
                                   && id_ex_cmd == 2'b10 && ex_mem_cmd == 2'b10));

    assert_safe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && (id_br || ex_br) && !(mem_br && mem_taken)) |->
        (pc_hold && if_id_cmd == 2'b01 && id_ex_cmd == 2'b10 && ex_mem_cmd == 2'b00));

    assert_spec_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !(mem_br && mem_taken)) |->
        (!pc_hold && !pc_redirect && if_id_cmd == 2'b00 && id_ex_cmd == 2'b00));

    assert_stall_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> stall_cnt == $past(stall_cnt) + CNT_W'(1));

    assert_stall_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_hold |=> $stable(stall_cnt));

    assert_squash_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_redirect |=> $stable(squash_cnt));

    assert_ignore_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_br |-> !pc_redirect);
endmodule

bind branch_hazard_ctrl bhc_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_branch_hazard_ctrl.sv
module sim_branch_hazard_ctrl;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0, id_br = 1'b0, ex_br = 1'b0, mem_br = 1'b0, mem_taken = 1'b0;
    logic [1:0] if_id_cmd, id_ex_cmd, ex_mem_cmd;
    logic pc_hold, pc_redirect;
    logic [W-1:0] stall_cnt, squash_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    branch_hazard_ctrl #(.CNT_W(W), .CANCEL_SLOTS(3)) u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic m, input logic i, input logic e,
                         input logic b, input logic t);
        @(negedge clk);
        mode = m; id_br = i; ex_br = e; mem_br = b; mem_taken = t;
        #1;
    endtask

    // one branch walking decode -> execute -> memory, then idle; returns penalty
    task automatic pass_branch(input logic m, input logic t, output int pen);
        int s0, q0;
        s0 = int'(stall_cnt); q0 = int'(squash_cnt);
        drive(m, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(m, 1'b0, 1'b1, 1'b0, 1'b0);
        drive(m, 1'b0, 1'b0, 1'b1, t);
        drive(m, 1'b0, 1'b0, 1'b0, 1'b0);
        pen = int'(stall_cnt) - s0 + int'(squash_cnt) - q0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 stall_cnt", int'(stall_cnt), 0);
        check("R1 squash_cnt", int'(squash_cnt), 0);

        // exhaustive sweep of mode and stage inputs
        for (int v = 0; v < 32; v++) begin
            logic m, i, e, b, t, tk, yb;
            int ei, ee, em, eh, er, es0, eq0, einc;
            {m, i, e, b, t} = 5'(v);
            tk = b & t;
            yb = i | e;
            if (tk) begin
                ei = 2; ee = 2; em = 2; eh = 0; er = 1;
            end else if (!m && yb) begin
                ei = 1; ee = 2; em = 0; eh = 1; er = 0;
            end else begin
                ei = 0; ee = 0; em = 0; eh = 0; er = 0;
            end
            es0 = int'(stall_cnt); eq0 = int'(squash_cnt);
            einc = tk ? (m ? 3 : 1) : 0;
            drive(m, i, e, b, t);
            if (tk) begin
                check("R4 if_id", int'(if_id_cmd), ei);
                check("R4 redirect", int'(pc_redirect), er);
                check("R4 hold", int'(pc_hold), eh);
            end else if (!m && yb) begin
                check("R3 if_id", int'(if_id_cmd), ei);
                check("R3 hold", int'(pc_hold), eh);
            end else if (m) begin
                check("R6 hold", int'(pc_hold), eh);
            end else if (b) begin
                check("R5 redirect", int'(pc_redirect), er);
            end else begin
                check("R2 if_id", int'(if_id_cmd), ei);
            end
            if (!b && t) check("R9 redirect", int'(pc_redirect), 0);
            check("R2 id_ex", int'(id_ex_cmd), ee);
            check("R2 ex_mem", int'(ex_mem_cmd), em);
            check("R2 redirect", int'(pc_redirect), er);
            check("R2 hold", int'(pc_hold), eh);
            @(negedge clk); #1;
            check("R7 stall delta", int'(stall_cnt) - es0, eh);
            check("R8 squash delta", int'(squash_cnt) - eq0, einc);
            mode = 1'b0; id_br = 1'b0; ex_br = 1'b0; mem_br = 1'b0; mem_taken = 1'b0;
        end

        pass_branch(1'b0, 1'b1, pen); check("R10 stall taken", pen, 3);
        pass_branch(1'b0, 1'b0, pen); check("R10 stall not-taken", pen, 2);
        pass_branch(1'b1, 1'b1, pen); check("R10 fetch taken", pen, 3);
        pass_branch(1'b1, 1'b0, pen); check("R10 fetch not-taken", pen, 0);

        // reset again clears counters
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 stall_cnt after reset", int'(stall_cnt), 0);
        check("R1 squash_cnt after reset", int'(squash_cnt), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule